// File: doc/BRIEF.md
# Three-Channel Compare and Wrap Timer

This peripheral holds three independent 32-bit counters behind a small word-addressed register bus. Each counter has a reload value and two compare values. It counts either upward or downward, on every bus clock or only on cycles where an external tick-enable input is high. When a counter wraps, it reloads itself. Each wrap and each compare hit is recorded in a shared nine-bit status register.

Software uses the block in two ways. For periodic interrupts, it programs a reload value and lets the counter wrap. For one-shot interrupts, it sets a compare value ahead of the running count. A mask register and a per-channel interrupt enable decide which recorded events drive the single combined interrupt line. A separate clear-only alias of the control register lets software stop a channel without a read-modify-write sequence.

Top module: `tri_timer`

## Requirements
- R1: After reset, every counter, reload, compare, control, status and mask register reads 0, and `irq` is low.
- R2: Word index `addr[5:2]` selects the register; `addr[1:0]` must be 0. A misaligned write is ignored and a misaligned read returns 0. For channel i (0..2), words 4i..4i+3 are count, reload, compare A and compare B. Word 12 is control, word 13 is status, word 14 is mask, and word 15 is control-clear, which reads as 0.
- R3: In up mode (control bit 9+i = 0), a tick with count 0xFFFFFFFF sets status bit 3i+2 and loads the reload value. Any other tick adds one. Loading 0xFFFFFFFF−(N−1) into both count and reload gives a wrap every N ticks.
- R4: In down mode (control bit 9+i = 1), a tick with count ≤ 1 sets status bit 3i+2 and loads the reload value. Any other tick subtracts one. Reload N gives a wrap every N ticks.
- R5: A tick that moves channel i's count to its compare A value sets status bit 3i. A tick that moves it to its compare B value sets status bit 3i+1.
- R6: With control bit 3i (run) at 0, channel i's count holds its value and the channel records no events.
- R7: With control bit 3i+1 (tick select) at 0, the channel ticks on every clock. With that bit at 1, it ticks only on clocks where `tick_in` is high.
- R8: A bus write to a count register replaces the count on that clock edge, and any tick in that cycle is dropped. The next tick advances from the written value.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it alone. An event in the same cycle as the clear keeps the bit set.
- R10: A write to the control-clear word clears each control bit whose written bit is 1 and leaves every other control bit unchanged.
- R11: `irq` is high exactly when some status bit is set whose mask bit is 0 and whose channel has control bit 3i+2 (interrupt enable) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_in | input | 1 | External tick enable for channels that select it |
| bus_wr | input | 1 | Write strobe, one word per clock |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt |

## Verification
The bench measures wrap periods in both directions by sampling status on the tick just before the wrap and on the wrap tick itself. A counter that is off by one, or a down counter that wraps at 0 instead of at 1, shows up as a status bit set one tick early or late. It races a status clear against a wrap in the same cycle: a design that gives the clear priority would drop that event. It also writes the count of a running channel to confirm the write wins over the tick, and it checks control-clear with a mixed bit pattern, which exposes an alias that overwrites bits instead of clearing them. Masking and the channel interrupt enable are each shown to hold `irq` low while the event stays recorded in status.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
  localparam int NCH    = 3;
  localparam int DW     = 32;
  localparam int AW     = 6;
  localparam int FPC    = 3;
  localparam int DIR_LO = NCH * FPC;
  localparam int CW     = NCH * FPC + NCH;
  localparam int NEV    = NCH * 3;

  localparam int F_RUN = 0;
  localparam int F_SEL = 1;
  localparam int F_IE  = 2;

  localparam int E_CMPA = 0;
  localparam int E_CMPB = 1;
  localparam int E_WRAP = 2;

  localparam logic [3:0] W_CTRL = 4'd12;
  localparam logic [3:0] W_STAT = 4'd13;
  localparam logic [3:0] W_MASK = 4'd14;
  localparam logic [3:0] W_CCLR = 4'd15;

  typedef struct packed {
    logic run;
    logic sel;
    logic down;
  } chan_cfg_t;
endpackage

// File: rtl/tt_chan.sv
module tt_chan
  import tri_timer_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  chan_cfg_t    cfg,
  input  logic         ext_tick,
  input  logic         wr_cnt,
  input  logic         wr_rld,
  input  logic         wr_cmpa,
  input  logic         wr_cmpb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rld_q,
  output logic [W-1:0] cmpa_q,
  output logic [W-1:0] cmpb_q,
  output logic [2:0]   ev
);
  logic         tick, live, wrap, cnt_ce;
  logic [W-1:0] step, adv, cnt_d;

  always_comb begin
    tick   = cfg.run & (cfg.sel ? ext_tick : 1'b1);
    live   = tick & ~wr_cnt;
    wrap   = cfg.down ? (cnt_q[W-1:1] == '0) : (&cnt_q);
    step   = cfg.down ? (cnt_q - W'(1)) : (cnt_q + W'(1));
    adv    = wrap ? rld_q : step;
    cnt_ce = wr_cnt | tick;
    cnt_d  = wr_cnt ? wdata : adv;
    ev[E_CMPA] = live & (adv == cmpa_q);
    ev[E_CMPB] = live & (adv == cmpb_q);
    ev[E_WRAP] = live & wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else begin
      if (cnt_ce)  cnt_q  <= cnt_d;
      if (wr_rld)  rld_q  <= wdata;
      if (wr_cmpa) cmpa_q <= wdata;
      if (wr_cmpb) cmpb_q <= wdata;
    end
  end
endmodule

// File: rtl/tt_decode.sv
module tt_decode
  import tri_timer_pkg::*;
#(
  parameter int W = DW
) (
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [NCH-1:0][W-1:0]  cnt_all,
  input  logic [NCH-1:0][W-1:0]  rld_all,
  input  logic [NCH-1:0][W-1:0]  cmpa_all,
  input  logic [NCH-1:0][W-1:0]  cmpb_all,
  input  logic [CW-1:0]          ctrl_q,
  input  logic [NEV-1:0]         stat_q,
  input  logic [NEV-1:0]         mask_q,
  output logic [NCH-1:0]         wr_cnt,
  output logic [NCH-1:0]         wr_rld,
  output logic [NCH-1:0]         wr_cmpa,
  output logic [NCH-1:0]         wr_cmpb,
  output logic                   wr_ctrl,
  output logic                   wr_stat,
  output logic                   wr_mask,
  output logic                   wr_cclr,
  output logic [W-1:0]           rdata
);
  localparam int WIW = AW - 2;

  logic           aligned, acc;
  logic [WIW-1:0] wi;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wi      = bus_addr[AW-1:2];
  assign acc     = bus_wr & aligned;

  for (genvar i = 0; i < NCH; i++) begin : g_wr
    logic hit;
    assign hit        = acc & (wi[WIW-1:2] == (WIW-2)'(i));
    assign wr_cnt[i]  = hit & (wi[1:0] == 2'd0);
    assign wr_rld[i]  = hit & (wi[1:0] == 2'd1);
    assign wr_cmpa[i] = hit & (wi[1:0] == 2'd2);
    assign wr_cmpb[i] = hit & (wi[1:0] == 2'd3);
  end

  assign wr_ctrl = acc & (wi == W_CTRL);
  assign wr_stat = acc & (wi == W_STAT);
  assign wr_mask = acc & (wi == W_MASK);
  assign wr_cclr = acc & (wi == W_CCLR);

  always_comb begin
    rdata = '0;
    if (aligned) begin
      for (int i = 0; i < NCH; i++) begin
        if (wi[WIW-1:2] == (WIW-2)'(i)) begin
          case (wi[1:0])
            2'd0:    rdata = cnt_all[i];
            2'd1:    rdata = rld_all[i];
            2'd2:    rdata = cmpa_all[i];
            default: rdata = cmpb_all[i];
          endcase
        end
      end
      case (wi)
        W_CTRL:  rdata = W'(ctrl_q);
        W_STAT:  rdata = W'(stat_q);
        W_MASK:  rdata = W'(mask_q);
        W_CCLR:  rdata = '0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tt_ctl.sv
module tt_ctl
  import tri_timer_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_ctrl,
  input  logic           wr_cclr,
  input  logic           wr_stat,
  input  logic           wr_mask,
  input  logic [CW-1:0]  wd_ctrl,
  input  logic [NEV-1:0] wd_ev,
  input  logic [NEV-1:0] ev,
  output logic [CW-1:0]  ctrl_q,
  output logic [NEV-1:0] stat_q,
  output logic [NEV-1:0] mask_q,
  output logic           irq
);
  logic [CW-1:0]  ctrl_d;
  logic [NEV-1:0] stat_d, clr_bits, ie_exp;
  logic           ctrl_ce, stat_ce;

  always_comb begin
    ctrl_ce  = wr_ctrl | wr_cclr;
    ctrl_d   = wr_ctrl ? wd_ctrl : (ctrl_q & ~wd_ctrl);
    clr_bits = wr_stat ? wd_ev : '0;
    stat_ce  = wr_stat | (|ev);
    stat_d   = (stat_q & ~clr_bits) | ev;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ie
    assign ie_exp[3*i +: 3] = {3{ctrl_q[FPC*i + F_IE]}};
  end

  assign irq = |(stat_q & ~mask_q & ie_exp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (stat_ce) stat_q <= stat_d;
      if (wr_mask) mask_q <= wd_ev;
    end
  end
endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tri_timer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_in,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic                  rs_meta, rst_s;
  logic [NCH-1:0][DW-1:0] cnt_all, rld_all, cmpa_all, cmpb_all;
  logic [NCH-1:0]        wr_cnt, wr_rld, wr_cmpa, wr_cmpb;
  logic                  wr_ctrl, wr_stat, wr_mask, wr_cclr;
  logic [CW-1:0]         ctrl_q;
  logic [NEV-1:0]        stat_q, mask_q, ev_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_s   <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_s   <= rs_meta;
    end
  end

  tt_decode #(.W(DW)) u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .cnt_all  (cnt_all),
    .rld_all  (rld_all),
    .cmpa_all (cmpa_all),
    .cmpb_all (cmpb_all),
    .ctrl_q   (ctrl_q),
    .stat_q   (stat_q),
    .mask_q   (mask_q),
    .wr_cnt   (wr_cnt),
    .wr_rld   (wr_rld),
    .wr_cmpa  (wr_cmpa),
    .wr_cmpb  (wr_cmpb),
    .wr_ctrl  (wr_ctrl),
    .wr_stat  (wr_stat),
    .wr_mask  (wr_mask),
    .wr_cclr  (wr_cclr),
    .rdata    (bus_rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_cfg_t cfg;
    assign cfg.run  = ctrl_q[FPC*i + F_RUN];
    assign cfg.sel  = ctrl_q[FPC*i + F_SEL];
    assign cfg.down = ctrl_q[DIR_LO + i];

    tt_chan #(.W(DW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_s),
      .cfg      (cfg),
      .ext_tick (tick_in),
      .wr_cnt   (wr_cnt[i]),
      .wr_rld   (wr_rld[i]),
      .wr_cmpa  (wr_cmpa[i]),
      .wr_cmpb  (wr_cmpb[i]),
      .wdata    (bus_wdata),
      .cnt_q    (cnt_all[i]),
      .rld_q    (rld_all[i]),
      .cmpa_q   (cmpa_all[i]),
      .cmpb_q   (cmpb_all[i]),
      .ev       (ev_all[3*i +: 3])
    );
  end

  tt_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_ctrl (wr_ctrl),
    .wr_cclr (wr_cclr),
    .wr_stat (wr_stat),
    .wr_mask (wr_mask),
    .wd_ctrl (bus_wdata[CW-1:0]),
    .wd_ev   (bus_wdata[NEV-1:0]),
    .ev      (ev_all),
    .ctrl_q  (ctrl_q),
    .stat_q  (stat_q),
    .mask_q  (mask_q),
    .irq     (irq)
  );
endmodule

// File: rtl/tt_chk.sv
module tt_chk
  import tri_timer_pkg::*;
(
  input logic                   clk,
  input logic                   rst_s,
  input logic                   bus_wr,
  input logic [AW-1:0]          bus_addr,
  input logic [CW-1:0]          wd,
  input logic [CW-1:0]          ctrl_q,
  input logic [NEV-1:0]         stat_q,
  input logic [NEV-1:0]         mask_q,
  input logic [NEV-1:0]         ev_all,
  input logic [NCH-1:0][DW-1:0] cnt_all,
  input logic                   irq
);
  logic       acc;
  logic [3:0] wi;
  assign acc = bus_wr && (bus_addr[1:0] == 2'b00);
  assign wi  = bus_addr[AW-1:2];

  // R9
  ev_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ev_all != '0) |=> ((stat_q & $past(ev_all)) == $past(ev_all)));

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc && wi == W_STAT) |=> ((stat_q & $past(wd[NEV-1:0] & ~ev_all)) == '0));

  // R10
  ctrl_clr_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc && wi == W_CCLR) |=> (ctrl_q == $past(ctrl_q & ~wd)));

  // R11
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (mask_q == '1) |-> !irq);

  for (genvar i = 0; i < NCH; i++) begin : g_c
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
      (!ctrl_q[FPC*i + F_RUN] && !(acc && wi == 4'(4*i))) |=> $stable(cnt_all[i]));
    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
      !ctrl_q[FPC*i + F_RUN] |-> (ev_all[3*i +: 3] == 3'b000));
  end
endmodule

bind tri_timer tt_chk u_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .wd       (bus_wdata[tri_timer_pkg::CW-1:0]),
  .ctrl_q   (ctrl_q),
  .stat_q   (stat_q),
  .mask_q   (mask_q),
  .ev_all   (ev_all),
  .cnt_all  (cnt_all),
  .irq      (irq)
);

// File: tb/tri_timer_bench.sv
module tri_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, tick_in, bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_timer u_tri_timer (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(6'h30, v); chk("R1 ctrl", v, 0);
    rd(6'h34, v); chk("R1 status", v, 0);
    rd(6'h00, v); chk("R1 count0", v, 0);
    rd(6'h2C, v); chk("R1 cmpb2", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_map;
    wr(6'h38, 32'h155); rd(6'h38, v); chk("R2 mask readback", v, 32'h155);
    wr(6'h24, 32'hCAFE0001); rd(6'h24, v); chk("R2 reload2 readback", v, 32'hCAFE0001);
    wr(6'h25, 32'h1); rd(6'h24, v); chk("R2 misaligned write ignored", v, 32'hCAFE0001);
    rd(6'h25, v); chk("R2 misaligned read", v, 0);
    wr(6'h38, 0);
  endtask

  task automatic t_up_period;
    wr(6'h00, 32'hFFFFFFFB); wr(6'h04, 32'hFFFFFFFB);
    wr(6'h30, 32'h005);
    idle(4);
    rd(6'h34, v); chk("R3 no wrap after 4 ticks", v & 32'h4, 0);
    idle(1);
    rd(6'h34, v); chk("R3 wrap on 5th tick", v & 32'h4, 32'h4);
    rd(6'h00, v); chk("R3 reloaded", v, 32'hFFFFFFFB);
    chk("R11 irq on wrap", {31'd0, irq}, 1);
    wr(6'h3C, 32'h1); wr(6'h34, 32'h1FF);
    rd(6'h34, v); chk("R9 status cleared", v, 0);
    chk("R11 irq low after clear", {31'd0, irq}, 0);
  endtask

  task automatic t_down_period;
    wr(6'h14, 3); wr(6'h10, 3);
    wr(6'h30, 32'h428);
    idle(2);
    rd(6'h10, v); chk("R4 count after 2 ticks", v, 1);
    rd(6'h34, v); chk("R4 no wrap yet", v & 32'h20, 0);
    idle(1);
    rd(6'h34, v); chk("R4 wrap on 3rd tick", v & 32'h20, 32'h20);
    rd(6'h10, v); chk("R4 reloaded", v, 3);
    wr(6'h3C, 32'h8); wr(6'h34, 32'h1FF);
  endtask

  task automatic t_compare;
    wr(6'h20, 0); wr(6'h28, 4); wr(6'h2C, 6);
    wr(6'h30, 32'h040);
    idle(3);
    rd(6'h34, v); chk("R5 no match at 3", v, 0);
    idle(1);
    rd(6'h34, v); chk("R5 compare A hit", v, 32'h40);
    idle(2);
    rd(6'h34, v); chk("R5 compare B hit", v, 32'hC0);
    chk("R11 irq low without channel enable", {31'd0, irq}, 0);
    wr(6'h3C, 32'h40); wr(6'h34, 32'h1FF);
  endtask

  task automatic t_ext_tick;
    tick_in = 1'b0;
    wr(6'h00, 10); wr(6'h30, 32'h003);
    idle(5);
    rd(6'h00, v); chk("R7 held without tick_in", v, 10);
    tick_in = 1'b1; idle(3); tick_in = 1'b0;
    rd(6'h00, v); chk("R7 three external ticks", v, 13);
    wr(6'h3C, 32'h1);
    tick_in = 1'b1; idle(4); tick_in = 1'b0;
    rd(6'h00, v); chk("R6 disabled count holds", v, 13);
    rd(6'h34, v); chk("R6 disabled records nothing", v, 0);
  endtask

  task automatic t_cnt_write;
    wr(6'h30, 32'h001);
    wr(6'h00, 100);
    rd(6'h00, v); chk("R8 write wins over tick", v, 100);
    idle(1);
    rd(6'h00, v); chk("R8 next tick from written value", v, 101);
    wr(6'h3C, 32'h1); wr(6'h34, 32'h1FF);
  endtask

  task automatic t_mask;
    wr(6'h38, 32'h1FF); wr(6'h04, 2); wr(6'h00, 2);
    wr(6'h30, 32'h205);
    idle(2);
    rd(6'h34, v); chk("R11 masked event still recorded", v & 32'h4, 32'h4);
    chk("R11 masked irq low", {31'd0, irq}, 0);
    wr(6'h38, 0);
    chk("R11 unmasked irq high", {31'd0, irq}, 1);
    wr(6'h3C, 32'h4);
    chk("R11 enable off irq low", {31'd0, irq}, 0);
    wr(6'h3C, 32'h201); wr(6'h34, 32'h1FF);
  endtask

  task automatic t_race;
    wr(6'h04, 2); wr(6'h00, 2);
    wr(6'h30, 32'h201);
    idle(3);
    wr(6'h34, 32'h4);
    rd(6'h34, v); chk("R9 event beats clear", v & 32'h4, 32'h4);
    wr(6'h34, 32'h4);
    rd(6'h34, v); chk("R9 clear without event", v & 32'h4, 0);
    wr(6'h3C, 32'hFFF); wr(6'h34, 32'h1FF);
  endtask

  task automatic t_ctrl_clr;
    wr(6'h30, 32'hFFF);
    wr(6'h3C, 32'h0A5);
    rd(6'h30, v); chk("R10 selective clear", v, 32'hF5A);
    rd(6'h3C, v); chk("R2 clear word reads 0", v, 0);
    wr(6'h3C, 32'hFFF);
    rd(6'h30, v); chk("R10 full clear", v, 0);
    wr(6'h34, 32'h1FF);
  endtask

  initial begin
    rst_n = 1'b0; tick_in = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset;
    t_map;
    t_up_period;
    t_down_period;
    t_compare;
    t_ext_tick;
    t_cnt_write;
    t_mask;
    t_race;
    t_ctrl_clr;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule